// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide programming front end of one eight-input interrupt controller. A CPU-side bus with a single address bit reaches two ports. Writes to the even port carry the start-of-setup word and the run-time command words. Writes to the odd port carry the remaining setup words while setup is in progress, and load the mask register at all other times. The block holds the mask, in-service and request registers, the current lowest-priority level, and the mode flags. A separate priority resolver reads these registers and tells the block which input it has granted.

The resolver connects through a small request/clear interface. `req_in` sets request bits. `ack_stb` with `ack_num` marks a grant, which clears the request bit and records the input as in service. `pick_num` is the resolver's current choice, and a poll read returns it. The `reeval` pulse tells the resolver to arbitrate again. A command that the block does not support raises the sticky `cmd_err` output and changes no other state.

The setup sequencer is a four-state machine. SEQ_RUN is normal operation. SEQ_W2 waits for the vector-base word. SEQ_W3 waits for the cascade word. SEQ_W4 waits for the mode word. The transitions are as follows. A valid start word moves the machine from any state to SEQ_W2. An odd write moves it from SEQ_W2 to SEQ_W3. An odd write moves it from SEQ_W3 to SEQ_W4 if a mode word was announced, and to SEQ_RUN otherwise. An odd write whose bit 0 is 1 moves it from SEQ_W4 to SEQ_RUN. An odd write whose bit 0 is 0 leaves it in SEQ_W4.

Top module: `irq_cmd_decoder`

## Requirements
- R1: After reset the mask register reads 0xFF, the in-service and request registers are 0, even-port reads return the request register, the lowest-priority level is 7, the sequencer is in SEQ_RUN and `cmd_err` is 0.
- R2: An even write with bit 4 = 1, bit 1 = 0 and bit 3 = 0 is a start word. It clears the mask, in-service and request registers. It sets the lowest-priority level to 7. It clears auto-EOI and rotate-on-auto-EOI. It pulses `drop_req` for one cycle and enters SEQ_W2. Its bit 0 announces a mode word.
- R3: During setup, odd writes are consumed in order. The first loads `vec_base` from bits 7:3. The second is accepted with no effect. The third is taken only if it was announced: it needs bit 0 = 1, and its bit 1 sets auto-EOI. `in_init` is 1 from the start word until the sequence ends.
- R4: An odd write in SEQ_RUN loads the mask register with the written byte.
- R5: An even write with bits 4:3 = 01 and bit 2 = 0 selects what even reads return: bits 1:0 = 10 select the request register and 11 select the in-service register. Odd reads return the mask register.
- R6: In that same word, bits 6:5 = 11 set special mask and bits 6:5 = 10 cancel it.
- R7: Even write 0x20 clears the highest-priority in-service bit. Priority starts one above the lowest-priority level and wraps modulo 8. Even write 0xA0 does the same and then advances the lowest-priority level by one, modulo 8.
- R8: Even write 0x60+n clears in-service bit n. Even write 0xE0+n clears in-service bit n and sets the lowest-priority level to n.
- R9: Even write 0xC0+n only sets the lowest-priority level to n. Even write 0x80 sets rotate-on-auto-EOI and 0x00 clears it. Even write 0x40 changes nothing.
- R10: An even write with bits 4:3 = 01 and bit 2 = 1 makes a poll pending. The next read of either port returns `pick_num` in bits 2:0, with zeros above. That read clears the highest-priority in-service bit and ends the poll.
- R11: `req_in` bits set request bits. `ack_stb` clears request bit `ack_num`. It sets the matching in-service bit when auto-EOI is off. When auto-EOI and rotate-on-auto-EOI are both on, it sets the lowest-priority level to `ack_num` instead.
- R12: The following are errors: a start word with bit 1 or bit 3 set, a mode word with bit 0 = 0, and any even-port code that is none of the above. Each sets `cmd_err`, which stays set until reset, and leaves all other state unchanged.
- R13: `reeval` is high for exactly the one cycle after any of these: a grant, a valid start word, a mask load, 0x20, 0xA0, 0x6n, 0xEn, 0xCn, a special-mask set or cancel, or a poll read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_a0 | input | 1 | Port select: 0 even, 1 odd |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| req_in | input | 8 | Request set pulses, one per input |
| ack_stb | input | 1 | Resolver grant strobe |
| ack_num | input | 3 | Granted input number |
| pick_num | input | 3 | Resolver's current choice, returned by a poll read |
| irq_mask | output | 8 | Mask register |
| irq_isr | output | 8 | In-service register |
| irq_irr | output | 8 | Request register |
| prio_low | output | 3 | Lowest-priority level |
| spec_mask | output | 1 | Special mask active |
| auto_eoi | output | 1 | Auto-EOI mode |
| rot_aeoi | output | 1 | Rotate on auto-EOI |
| vec_base | output | 5 | Vector base bits 7:3 |
| in_init | output | 1 | Setup sequence in progress |
| poll_pend | output | 1 | Poll pending |
| reeval | output | 1 | Re-arbitrate pulse |
| drop_req | output | 1 | Drop pending output request pulse |
| cmd_err | output | 1 | Sticky unsupported-command flag |

## Verification
The non-specific end-of-interrupt commands run with several in-service patterns and several lowest-priority levels. This shows whether the scan wraps from the rotated start point and does not simply take the lowest bit. Specific end-of-interrupt and set-priority codes are interleaved with grants, which separates clearing a bit from changing priority. Setup runs both with and without the mode word, and once with a rejected mode word. This checks that the sequencer waits in the right state and that an odd write lands in the mask register only outside setup. A poll read runs while two inputs are in service, which shows that it returns the resolver's choice and clears only the winning bit.

// File: rtl/icd_pkg.sv
package icd_pkg;
    localparam int unsigned ICD_DW  = 8;
    localparam int unsigned ICD_NIN = 8;

    typedef enum logic [1:0] {
        SEQ_RUN,
        SEQ_W2,
        SEQ_W3,
        SEQ_W4
    } seq_state_e;

    typedef enum logic [3:0] {
        CMD_ICW_START,
        CMD_ICW_BAD,
        CMD_SEL_WORD,
        CMD_EOI_ANY,
        CMD_EOI_ANY_ROT,
        CMD_EOI_ONE,
        CMD_EOI_ONE_ROT,
        CMD_SET_LOW,
        CMD_ROT_AEOI,
        CMD_NOP,
        CMD_UNSUP
    } cmd_e;
endpackage

// File: rtl/icd_cmd_decode.sv
module icd_cmd_decode
    import icd_pkg::*;
#(
    parameter int unsigned DW = ICD_DW
) (
    input  logic [DW-1:0] wd,
    output cmd_e          kind
);
    always_comb begin
        kind = CMD_UNSUP;
        if (wd[4]) begin
            kind = (wd[1] || wd[3]) ? CMD_ICW_BAD : CMD_ICW_START;
        end else if (wd[3]) begin
            kind = CMD_SEL_WORD;
        end else begin
            unique case (wd[7:5])
                3'b001: kind = (wd[2:0] == 3'd0) ? CMD_EOI_ANY : CMD_UNSUP;
                3'b101: kind = (wd[2:0] == 3'd0) ? CMD_EOI_ANY_ROT : CMD_UNSUP;
                3'b011: kind = CMD_EOI_ONE;
                3'b111: kind = CMD_EOI_ONE_ROT;
                3'b110: kind = CMD_SET_LOW;
                3'b000,
                3'b100: kind = (wd[2:0] == 3'd0) ? CMD_ROT_AEOI : CMD_UNSUP;
                3'b010: kind = (wd[2:0] == 3'd0) ? CMD_NOP : CMD_UNSUP;
                default: kind = CMD_UNSUP;
            endcase
        end
    end
endmodule

// File: rtl/icd_hi_find.sv
module icd_hi_find #(
    parameter int unsigned N  = 8,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    input  logic [IW-1:0] low,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        // scan from lowest priority up to highest so the last hit wins
        for (int k = N; k >= 1; k--) begin
            if (vec[(int'(low) + k) % N]) begin
                found = 1'b1;
                idx   = IW'((int'(low) + k) % N);
            end
        end
    end
endmodule

// File: rtl/icd_init_seq.sv
module icd_init_seq
    import icd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic need4,
    input  logic odd_wr,
    input  logic w4_ok,
    output logic in_init,
    output logic take_w2,
    output logic take_w4,
    output logic bad_w4
);
    seq_state_e state_q, state_n;
    logic       need4_q;

    always_comb begin
        state_n = state_q;
        if (start) begin
            state_n = SEQ_W2;
        end else if (odd_wr) begin
            unique case (state_q)
                SEQ_RUN: state_n = SEQ_RUN;
                SEQ_W2:  state_n = SEQ_W3;
                SEQ_W3:  state_n = need4_q ? SEQ_W4 : SEQ_RUN;
                SEQ_W4:  state_n = w4_ok ? SEQ_RUN : SEQ_W4;
                default: state_n = SEQ_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_RUN;
            need4_q <= 1'b0;
        end else begin
            state_q <= state_n;
            if (start) need4_q <= need4;
        end
    end

    always_comb begin
        in_init = 1'b1;
        take_w2 = 1'b0;
        take_w4 = 1'b0;
        bad_w4  = 1'b0;
        unique case (state_q)
            SEQ_RUN: in_init = 1'b0;
            SEQ_W2:  take_w2 = odd_wr;
            SEQ_W3:  ;
            SEQ_W4: begin
                take_w4 = odd_wr && w4_ok;
                bad_w4  = odd_wr && !w4_ok;
            end
            default: in_init = 1'b0;
        endcase
    end

    AST_W2_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_W2 && odd_wr && !start) |=> (state_q == SEQ_W3)); // R3
    AST_W4_ANNOUNCED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_W3 && odd_wr && !start && !need4_q) |=> (state_q == SEQ_RUN)); // R3
    AST_W4_HOLDS_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_W4 && odd_wr && !w4_ok && !start) |=> (state_q == SEQ_W4)); // R12
endmodule

// File: rtl/irq_cmd_decoder.sv
module irq_cmd_decoder
    import icd_pkg::*;
#(
    parameter int unsigned DW  = ICD_DW,
    parameter int unsigned NIN = ICD_NIN,
    localparam int unsigned IW = $clog2(NIN),
    localparam int unsigned BW = DW - IW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic           bus_a0,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [NIN-1:0] req_in,
    input  logic           ack_stb,
    input  logic [IW-1:0]  ack_num,
    input  logic [IW-1:0]  pick_num,
    output logic [NIN-1:0] irq_mask,
    output logic [NIN-1:0] irq_isr,
    output logic [NIN-1:0] irq_irr,
    output logic [IW-1:0]  prio_low,
    output logic           spec_mask,
    output logic           auto_eoi,
    output logic           rot_aeoi,
    output logic [BW-1:0]  vec_base,
    output logic           in_init,
    output logic           poll_pend,
    output logic           reeval,
    output logic           drop_req,
    output logic           cmd_err
);
    logic [NIN-1:0] mask_q, mask_n, isr_q, isr_n, irr_q, irr_n;
    logic [IW-1:0]  low_q, low_n;
    logic [BW-1:0]  vb_q, vb_n;
    logic smm_q, smm_n, aeoi_q, aeoi_n, raeoi_q, raeoi_n;
    logic sel_isr_q, sel_isr_n, poll_q, poll_n, err_q, err_n;
    logic reeval_q, reeval_n, drop_q, drop_n;

    logic even_wr, odd_wr, poll_rd;
    cmd_e wcmd;
    logic hf_found;
    logic [IW-1:0] hf_idx;
    logic take_w2, take_w4, bad_w4;

    assign even_wr = bus_wr && !bus_a0;
    assign odd_wr  = bus_wr && bus_a0;
    assign poll_rd = bus_rd && poll_q;

    icd_cmd_decode #(.DW(DW)) u_dec (
        .wd   (bus_wdata),
        .kind (wcmd)
    );

    icd_hi_find #(.N(NIN)) u_find (
        .vec   (isr_q),
        .low   (low_q),
        .found (hf_found),
        .idx   (hf_idx)
    );

    icd_init_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (even_wr && wcmd == CMD_ICW_START),
        .need4   (bus_wdata[0]),
        .odd_wr  (odd_wr),
        .w4_ok   (bus_wdata[0]),
        .in_init (in_init),
        .take_w2 (take_w2),
        .take_w4 (take_w4),
        .bad_w4  (bad_w4)
    );

    always_comb begin
        mask_n    = mask_q;
        isr_n     = isr_q;
        low_n     = low_q;
        vb_n      = vb_q;
        smm_n     = smm_q;
        aeoi_n    = aeoi_q;
        raeoi_n   = raeoi_q;
        sel_isr_n = sel_isr_q;
        poll_n    = poll_q;
        err_n     = err_q;
        reeval_n  = 1'b0;
        drop_n    = 1'b0;
        irr_n     = irr_q | req_in;

        if (ack_stb) begin
            irr_n[ack_num] = 1'b0;
            if (!aeoi_q)      isr_n[ack_num] = 1'b1;
            else if (raeoi_q) low_n = ack_num;
            reeval_n = 1'b1;
        end

        if (poll_rd) begin
            if (hf_found) isr_n[hf_idx] = 1'b0;
            poll_n   = 1'b0;
            reeval_n = 1'b1;
        end

        if (even_wr) begin
            unique case (wcmd)
                CMD_ICW_START: begin
                    mask_n   = '0;
                    isr_n    = '0;
                    irr_n    = '0;
                    low_n    = '1;
                    aeoi_n   = 1'b0;
                    raeoi_n  = 1'b0;
                    drop_n   = 1'b1;
                    reeval_n = 1'b1;
                end
                CMD_SEL_WORD: begin
                    if (bus_wdata[2]) begin
                        poll_n = 1'b1;
                    end else begin
                        if (bus_wdata[1]) sel_isr_n = bus_wdata[0];
                        if (bus_wdata[6]) begin
                            smm_n    = bus_wdata[5];
                            reeval_n = 1'b1;
                        end
                    end
                end
                CMD_EOI_ANY: begin
                    if (hf_found) isr_n[hf_idx] = 1'b0;
                    reeval_n = 1'b1;
                end
                CMD_EOI_ANY_ROT: begin
                    if (hf_found) isr_n[hf_idx] = 1'b0;
                    low_n    = low_q + 1'b1;
                    reeval_n = 1'b1;
                end
                CMD_EOI_ONE: begin
                    isr_n[bus_wdata[IW-1:0]] = 1'b0;
                    reeval_n = 1'b1;
                end
                CMD_EOI_ONE_ROT: begin
                    isr_n[bus_wdata[IW-1:0]] = 1'b0;
                    low_n    = bus_wdata[IW-1:0];
                    reeval_n = 1'b1;
                end
                CMD_SET_LOW: begin
                    low_n    = bus_wdata[IW-1:0];
                    reeval_n = 1'b1;
                end
                CMD_ROT_AEOI: raeoi_n = bus_wdata[DW-1];
                CMD_NOP:      ;
                CMD_ICW_BAD,
                CMD_UNSUP:    err_n = 1'b1;
                default:      err_n = 1'b1;
            endcase
        end

        if (odd_wr) begin
            if (in_init) begin
                if (take_w2) vb_n   = bus_wdata[DW-1:IW];
                if (take_w4) aeoi_n = bus_wdata[1];
                if (bad_w4)  err_n  = 1'b1;
            end else begin
                mask_n   = bus_wdata;
                reeval_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q    <= '1;
            isr_q     <= '0;
            irr_q     <= '0;
            low_q     <= '1;
            vb_q      <= '0;
            smm_q     <= 1'b0;
            aeoi_q    <= 1'b0;
            raeoi_q   <= 1'b0;
            sel_isr_q <= 1'b0;
            poll_q    <= 1'b0;
            err_q     <= 1'b0;
            reeval_q  <= 1'b0;
            drop_q    <= 1'b0;
        end else begin
            mask_q    <= mask_n;
            isr_q     <= isr_n;
            irr_q     <= irr_n;
            low_q     <= low_n;
            vb_q      <= vb_n;
            smm_q     <= smm_n;
            aeoi_q    <= aeoi_n;
            raeoi_q   <= raeoi_n;
            sel_isr_q <= sel_isr_n;
            poll_q    <= poll_n;
            err_q     <= err_n;
            reeval_q  <= reeval_n;
            drop_q    <= drop_n;
        end
    end

    always_comb begin
        if (poll_q)      bus_rdata = {{BW{1'b0}}, pick_num};
        else if (bus_a0) bus_rdata = mask_q;
        else             bus_rdata = sel_isr_q ? isr_q : irr_q;
    end

    assign irq_mask  = mask_q;
    assign irq_isr   = isr_q;
    assign irq_irr   = irr_q;
    assign prio_low  = low_q;
    assign spec_mask = smm_q;
    assign auto_eoi  = aeoi_q;
    assign rot_aeoi  = raeoi_q;
    assign vec_base  = vb_q;
    assign poll_pend = poll_q;
    assign reeval    = reeval_q;
    assign drop_req  = drop_q;
    assign cmd_err   = err_q;

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (even_wr && wcmd == CMD_ICW_START) |=>
        (irq_mask == '0 && irq_isr == '0 && irq_irr == '0 && prio_low == '1 && drop_req)); // R2
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (odd_wr && !in_init) |=> (irq_mask == $past(bus_wdata) && reeval)); // R4
    AST_ONE_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (even_wr && wcmd == CMD_EOI_ONE) |=> !irq_isr[$past(bus_wdata[IW-1:0])]); // R8
    AST_POLL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_rd && !bus_wr) |=> !poll_pend); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> cmd_err); // R12
endmodule

// File: tb/irq_cmd_decoder_test.sv
`timescale 1ns/1ps
module irq_cmd_decoder_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0, bus_a0 = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] req_in = 8'h00;
    logic ack_stb = 1'b0;
    logic [2:0] ack_num = 3'd0;
    logic [2:0] pick_num = 3'd3;
    logic [7:0] irq_mask, irq_isr, irq_irr;
    logic [2:0] prio_low;
    logic spec_mask, auto_eoi, rot_aeoi, in_init, poll_pend, reeval, drop_req, cmd_err;
    logic [4:0] vec_base;

    int nchk = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    irq_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_a0(bus_a0),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_in(req_in),
        .ack_stb(ack_stb), .ack_num(ack_num), .pick_num(pick_num),
        .irq_mask(irq_mask), .irq_isr(irq_isr), .irq_irr(irq_irr), .prio_low(prio_low),
        .spec_mask(spec_mask), .auto_eoi(auto_eoi), .rot_aeoi(rot_aeoi), .vec_base(vec_base),
        .in_init(in_init), .poll_pend(poll_pend), .reeval(reeval), .drop_req(drop_req),
        .cmd_err(cmd_err)
    );

    // behavioural reference model
    logic [7:0] m_mask, m_isr, m_irr;
    logic [4:0] m_vb;
    int m_low, m_step;
    bit m_smm, m_aeoi, m_raeoi, m_sel, m_poll, m_err, m_reeval, m_drop, m_need4;

    function automatic int top_bit(input logic [7:0] v, input int low);
        for (int k = 1; k <= 8; k++) begin
            if (v[(low + k) % 8]) return (low + k) % 8;
        end
        return -1;
    endfunction

    always @(posedge clk) begin : model
        bit rv, dp;
        int h;
        logic [7:0] v;
        if (!rst_n) begin
            m_mask = 8'hFF; m_isr = 0; m_irr = 0; m_vb = 0; m_low = 7; m_step = 0;
            m_smm = 0; m_aeoi = 0; m_raeoi = 0; m_sel = 0; m_poll = 0; m_err = 0;
            m_reeval = 0; m_drop = 0; m_need4 = 0;
        end else begin
            rv = 0; dp = 0; v = bus_wdata;
            m_irr = m_irr | req_in;
            if (ack_stb) begin
                m_irr[ack_num] = 1'b0;
                if (!m_aeoi) m_isr[ack_num] = 1'b1;
                else if (m_raeoi) m_low = int'(ack_num);
                rv = 1;
            end
            if (bus_rd && m_poll) begin
                h = top_bit(m_isr, m_low);
                if (h >= 0) m_isr[h] = 1'b0;
                m_poll = 0; rv = 1;
            end
            if (bus_wr && !bus_a0) begin
                if (v[4]) begin
                    if (v[1] || v[3]) m_err = 1;
                    else begin
                        m_mask = 0; m_isr = 0; m_irr = 0; m_low = 7; m_aeoi = 0; m_raeoi = 0;
                        m_step = 2; m_need4 = v[0]; dp = 1; rv = 1;
                    end
                end else if (v[3]) begin
                    if (v[2]) m_poll = 1;
                    else begin
                        if (v[1:0] == 2'b10) m_sel = 0;
                        if (v[1:0] == 2'b11) m_sel = 1;
                        if (v[6]) begin m_smm = v[5]; rv = 1; end
                    end
                end else if (v == 8'h20 || v == 8'hA0) begin
                    h = top_bit(m_isr, m_low);
                    if (h >= 0) m_isr[h] = 1'b0;
                    if (v == 8'hA0) m_low = (m_low + 1) % 8;
                    rv = 1;
                end else if (v >= 8'h60 && v <= 8'h67) begin
                    m_isr[v - 8'h60] = 1'b0; rv = 1;
                end else if (v >= 8'hE0) begin
                    m_isr[v - 8'hE0] = 1'b0; m_low = int'(v - 8'hE0); rv = 1;
                end else if (v >= 8'hC0 && v <= 8'hC7) begin
                    m_low = int'(v - 8'hC0); rv = 1;
                end else if (v == 8'h00 || v == 8'h80) begin
                    m_raeoi = v[7];
                end else if (v != 8'h40) begin
                    m_err = 1;
                end
            end
            if (bus_wr && bus_a0) begin
                if (m_step == 2) begin m_vb = v[7:3]; m_step = 3; end
                else if (m_step == 3) m_step = m_need4 ? 4 : 0;
                else if (m_step == 4) begin
                    if (v[0]) begin m_aeoi = v[1]; m_step = 0; end
                    else m_err = 1;
                end else begin
                    m_mask = v; rv = 1;
                end
            end
            m_reeval = rv; m_drop = dp;
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(irq_mask, m_mask, "R4 mask");
            chk(irq_isr, m_isr, "R7 isr");
            chk(irq_irr, m_irr, "R11 irr");
            chk({5'd0, prio_low}, 8'(m_low), "R9 lowest");
            chk({7'd0, spec_mask}, {7'd0, m_smm}, "R6 special mask");
            chk({7'd0, auto_eoi}, {7'd0, m_aeoi}, "R3 auto-eoi");
            chk({7'd0, rot_aeoi}, {7'd0, m_raeoi}, "R9 rotate");
            chk({3'd0, vec_base}, {3'd0, m_vb}, "R3 vector base");
            chk({7'd0, in_init}, {7'd0, (m_step != 0)}, "R3 in_init");
            chk({7'd0, poll_pend}, {7'd0, m_poll}, "R10 poll");
            chk({7'd0, reeval}, {7'd0, m_reeval}, "R13 reeval");
            chk({7'd0, drop_req}, {7'd0, m_drop}, "R2 drop");
            chk({7'd0, cmd_err}, {7'd0, m_err}, "R12 error");
        end
    end

    task automatic step_clear();
        @(negedge clk); #1;
        bus_wr = 0; bus_rd = 0; ack_stb = 0; req_in = 0;
    endtask
    task automatic idle(); step_clear(); endtask
    task automatic wr(input logic a0, input logic [7:0] d);
        step_clear(); bus_wr = 1; bus_a0 = a0; bus_wdata = d;
    endtask
    task automatic rd(input logic a0, input logic [7:0] exp, input string tag);
        step_clear(); bus_rd = 1; bus_a0 = a0; #1;
        chk(bus_rdata, exp, tag);
    endtask
    task automatic ack(input int n);
        step_clear(); ack_stb = 1; ack_num = 3'(n);
    endtask
    task automatic req(input logic [7:0] r);
        step_clear(); req_in = r;
    endtask
    task automatic do_reset();
        step_clear(); rst_n = 0;
        repeat (2) @(negedge clk);
        #1 rst_n = 1;
    endtask

    initial begin : watchdog
        #(5.0 * 100000);
        nerr++; nchk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        do_reset();
        idle();
        // R1 reset state
        chk(irq_mask, 8'hFF, "R1 mask");
        chk(irq_isr, 8'h00, "R1 isr");
        chk({5'd0, prio_low}, 8'd7, "R1 lowest");
        rd(1, 8'hFF, "R1 odd read");
        rd(0, 8'h00, "R1 even read selects request");
        // R2/R3 full setup with mode word
        wr(0, 8'h11); idle();
        chk({7'd0, drop_req}, 8'd1, "R2 drop pulse");
        chk(irq_mask, 8'h00, "R2 mask cleared");
        wr(1, 8'h48); wr(1, 8'h04); idle();
        chk({7'd0, in_init}, 8'd1, "R3 waits for mode word");
        wr(1, 8'h01); idle();
        chk({7'd0, in_init}, 8'd0, "R3 sequence done");
        chk({3'd0, vec_base}, 8'd9, "R3 vector base");
        // R4 / R13 mask load
        wr(1, 8'hF0); idle();
        chk(irq_mask, 8'hF0, "R4 mask");
        chk({7'd0, reeval}, 8'd1, "R13 reeval after mask");
        idle();
        chk({7'd0, reeval}, 8'd0, "R13 reeval one cycle");
        rd(1, 8'hF0, "R5 odd read mask");
        // R11 requests and grants
        req(8'h0C);
        rd(0, 8'h0C, "R11 request bits");
        ack(2); ack(3); idle();
        chk(irq_isr, 8'h0C, "R11 grants in service");
        chk(irq_irr, 8'h00, "R11 grants clear requests");
        // R5 select in-service
        wr(0, 8'h0B);
        rd(0, 8'h0C, "R5 even read in-service");
        // R7 non-specific EOI
        wr(0, 8'h20); idle();
        chk(irq_isr, 8'h08, "R7 clears bit 2");
        ack(5); wr(0, 8'hC4); wr(0, 8'h20); idle();
        chk(irq_isr, 8'h08, "R7 rotated clears bit 5");
        chk({5'd0, prio_low}, 8'd4, "R9 set lowest");
        wr(0, 8'hA0); idle();
        chk(irq_isr, 8'h00, "R7 rotate EOI clears bit 3");
        chk({5'd0, prio_low}, 8'd5, "R7 lowest advances");
        // R8 specific EOI
        ack(1); ack(6); wr(0, 8'h66); idle();
        chk(irq_isr, 8'h02, "R8 specific clear");
        wr(0, 8'hE1); idle();
        chk(irq_isr, 8'h00, "R8 clear and rotate");
        chk({5'd0, prio_low}, 8'd1, "R8 lowest set");
        // R9 no-op and rotate flag
        wr(0, 8'h40); idle();
        chk({5'd0, prio_low}, 8'd1, "R9 no-op lowest");
        chk(irq_mask, 8'hF0, "R9 no-op mask");
        wr(0, 8'h80); idle();
        chk({7'd0, rot_aeoi}, 8'd1, "R9 rotate set");
        wr(0, 8'h00); idle();
        chk({7'd0, rot_aeoi}, 8'd0, "R9 rotate clear");
        // R6 special mask
        wr(0, 8'h68); idle();
        chk({7'd0, spec_mask}, 8'd1, "R6 set");
        wr(0, 8'h48); idle();
        chk({7'd0, spec_mask}, 8'd0, "R6 cancel");
        // R10 poll
        ack(0); ack(7); wr(0, 8'h0C); idle();
        chk({7'd0, poll_pend}, 8'd1, "R10 pending");
        rd(0, 8'h03, "R10 poll read value");
        idle();
        chk(irq_isr, 8'h01, "R10 poll clears highest");
        chk({7'd0, poll_pend}, 8'd0, "R10 poll ends");
        // R12 errors leave state
        wr(0, 8'h02); idle();
        chk({7'd0, cmd_err}, 8'd1, "R12 undefined code");
        chk(irq_isr, 8'h01, "R12 state kept");
        wr(0, 8'h13); idle();
        chk({7'd0, in_init}, 8'd0, "R12 bad start ignored");
        chk(irq_mask, 8'hF0, "R12 bad start mask kept");
        // rejected mode word after fresh reset
        do_reset();
        wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h00); idle();
        chk({7'd0, cmd_err}, 8'd1, "R12 bad mode word");
        chk({7'd0, in_init}, 8'd1, "R12 still waiting");
        wr(1, 8'h03); idle();
        chk({7'd0, auto_eoi}, 8'd1, "R3 auto-eoi on");
        chk({3'd0, vec_base}, 8'd4, "R3 vector base second");
        // R11 auto-EOI grants
        req(8'h10); ack(4); idle();
        chk(irq_isr, 8'h00, "R11 auto-eoi no in-service");
        chk(irq_irr, 8'h00, "R11 request cleared");
        wr(0, 8'h80); ack(6); idle();
        chk({5'd0, prio_low}, 8'd6, "R11 rotate on grant");
        // R2 re-start without mode word
        wr(1, 8'h5A); wr(0, 8'h10); idle();
        chk(irq_mask, 8'h00, "R2 restart clears mask");
        chk({7'd0, rot_aeoi}, 8'd0, "R2 rotate cleared");
        chk({7'd0, auto_eoi}, 8'd0, "R2 auto-eoi cleared");
        wr(1, 8'h08); wr(1, 8'h04); wr(1, 8'h33); idle();
        chk(irq_mask, 8'h33, "R3 short sequence then mask");
        idle();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule